// File: doc/BRIEF.md
# Three-Lane 7:1 Serializer with Clock Lane

This block turns a 21-bit parallel pixel word into three serial data lanes running at seven times the pixel rate. A fourth lane carries a copy of the pixel clock that is in phase with the serial words. The parallel bus is captured on either the rising or the falling edge of the pixel clock, chosen by a pin. The captured word is then re-registered in the fast bit-clock domain. A single shared slot sequencer loads all four lane shift registers together and shifts them once per bit clock.

The bit clock comes from outside the block and is phase-locked to the pixel clock at 7x. A pixel-clock rising edge falls inside slot 0 of every word period, and a falling edge falls inside slot 4. An active-low shutdown clears every register in both clock domains and forces all lane bits and lane enables low. After shutdown is released, the lanes stay quiet for one full word period and then switch on together at the first load.

Top module: `ser7_tx`

## Requirements
- R1: Bus bits 0..6 are sent on lane 0, bits 7..13 on lane 1 and bits 14..20 on lane 2. Lane index 3 of `lane_out` is the clock lane.
- R2: Each word period has seven bit-clock slots numbered 0..6. In slot s, data lane L outputs bus bit 7*L+6-s, so the most significant bit of the lane goes first and one bit is sent per bit-clock cycle.
- R3: With `edge_sel` = 1 the bus is captured on the pixel-clock rising edge. With `edge_sel` = 0 it is captured on the falling edge. The selection is read once per word, at the bit-clock edge that ends slot 2.
- R4: A word is always sent whole within one word period and is never torn. Two captures feed period n+1: the rising-edge capture made during slot 0 of period n, and the falling-edge capture made during slot 4 of period n-1. All lanes load together at the end of slot 6.
- R5: While enabled, the clock lane is 1 in slots 0..3 and 0 in slots 4..6, which is the cyclic pattern 1100011. Its 0-to-1 transition coincides with slot 0 of the data lanes.
- R6: If `shutdown_n` is low at a bit-clock edge, all four lane bits and all four enables are 0 in the following cycle. All captured and buffered words are cleared.
- R7: After `shutdown_n` is released, outputs and enables stay 0 for the first word period. The enables then rise at slot 0 of the next period. That period carries an all-zero data word, because the captures were cleared.
- R8: The four enables always carry the same value, and once set they stay high until shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Fast serial clock, 7x the pixel clock, phase-locked |
| pix_clk | input | 1 | Pixel clock that qualifies the parallel bus |
| shutdown_n | input | 1 | Active-low synchronous clear and lane disable |
| edge_sel | input | 1 | 1: capture on pixel rising edge, 0: on falling edge |
| pix_data | input | 21 | Parallel data, three 7-bit lane groups |
| lane_out | output | 4 | Serial bits: [2:0] data lanes, [3] clock lane |
| lane_en | output | 4 | Per-lane driver enables |

## Verification
The assertions rely on three input assumptions. First, shutdown is released on the bit-clock edge that opens a word period. Second, the pixel clock keeps its fixed phase: a rise early in slot 0 and a fall early in slot 4. Together these make the clock-lane runs of four ones and three zeros hold from the first enabled slot onward. Third, the parallel bus and the edge select stay stable around the pixel edges and the slot-2 resample. The stimulus builds the pixel clock as a fixed offset from the bit clock and changes the bus only midway between pixel edges. It drives two different words per period so that the two capture edges see different values. It also asserts shutdown at an arbitrary bit-clock edge but releases it only on a period boundary.

// File: rtl/ser7_pkg.sv
// Package: shared constants and helpers for the 7:1 serializer.
// Assumes lane width never exceeds 32 bits.
package ser7_pkg;

    // Widest lane word the helper functions support.
    localparam int unsigned SER7_MAX_BITS = 32;

    // Build a word whose 'ones' most significant bits of an n-bit field are set.
    function automatic logic [SER7_MAX_BITS-1:0] lead_ones(input int unsigned n,
                                                           input int unsigned ones);
        logic [SER7_MAX_BITS-1:0] v;
        v = '0;
        for (int unsigned i = 0; i < n; i++) begin
            if (i < ones) begin
                v[n-1-i] = 1'b1;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/ser7_capture.sv
// Module: ser7_capture
// Captures the parallel bus on both pixel-clock edges into separate registers.
// The fast domain picks one of them, so no clock mux is needed.
// Assumes shutdown_n is held low across at least one edge of each polarity.
module ser7_capture #(
    parameter int unsigned W = 21
) (
    input  logic         pix_clk,
    input  logic         shutdown_n,
    input  logic [W-1:0] pix_data,
    output logic [W-1:0] cap_rise,
    output logic [W-1:0] cap_fall
);

    // Rising-edge capture of the bus, cleared synchronously by shutdown.
    always_ff @(posedge pix_clk) begin
        if (!shutdown_n) begin
            cap_rise <= '0;
        end else begin
            cap_rise <= pix_data;
        end
    end

    // Falling-edge capture of the bus, cleared synchronously by shutdown.
    always_ff @(negedge pix_clk) begin
        if (!shutdown_n) begin
            cap_fall <= '0;
        end else begin
            cap_fall <= pix_data;
        end
    end

endmodule

// File: rtl/ser7_seq.sv
// Module: ser7_seq
// Shared slot sequencer in the bit-clock domain.
// It counts slots 0..BITS-1, resamples the selected capture at SAMPLE_SLOT,
// raises load in the last slot, and latches the lane enable at the first load.
// Assumes both capture registers are stable at the end of SAMPLE_SLOT.
module ser7_seq #(
    parameter int unsigned BITS        = 7,
    parameter int unsigned W           = 21,
    parameter int unsigned SAMPLE_SLOT = 2
) (
    input  logic         bit_clk,
    input  logic         shutdown_n,
    input  logic         edge_sel,
    input  logic [W-1:0] cap_rise,
    input  logic [W-1:0] cap_fall,
    output logic         load,
    output logic [W-1:0] word,
    output logic         active
);

    localparam int unsigned CW        = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [CW-1:0] LAST    = CW'(BITS - 1);
    localparam logic [CW-1:0] SAMPLE  = CW'(SAMPLE_SLOT);

    logic [CW-1:0] slot;

    // Slot counter: wraps from the last slot back to slot 0.
    always_ff @(posedge bit_clk) begin
        if (!shutdown_n) begin
            slot <= '0;
        end else if (slot == LAST) begin
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

    // The load strobe covers the whole last slot, so the next slot 0 carries a fresh MSB.
    assign load = (slot == LAST);

    // Fast-domain resample of the chosen capture, taken once per word.
    always_ff @(posedge bit_clk) begin
        if (!shutdown_n) begin
            word <= '0;
        end else if (slot == SAMPLE) begin
            word <= edge_sel ? cap_rise : cap_fall;
        end
    end

    // Lane enable: set by the first load after release, cleared by shutdown.
    always_ff @(posedge bit_clk) begin
        if (!shutdown_n) begin
            active <= 1'b0;
        end else if (load) begin
            active <= 1'b1;
        end
    end

endmodule

// File: rtl/ser7_lane.sv
// Module: ser7_lane
// One parallel-in serial-out lane that sends the MSB first.
// It loads on 'load' and otherwise shifts toward the MSB, filling with zero.
// Assumes load is a one-cycle-per-word strobe from the shared sequencer.
module ser7_lane #(
    parameter int unsigned BITS = 7
) (
    input  logic            bit_clk,
    input  logic            shutdown_n,
    input  logic            load,
    input  logic [BITS-1:0] din,
    output logic            sout
);

    logic [BITS-1:0] shreg;

    // Shift register: parallel load on strobe, otherwise shift one place per bit clock.
    always_ff @(posedge bit_clk) begin
        if (!shutdown_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= din;
        end else begin
            shreg <= {shreg[BITS-2:0], 1'b0};
        end
    end

    assign sout = shreg[BITS-1];

endmodule

// File: rtl/ser7_tx.sv
// Module: ser7_tx (top)
// Three data lanes plus one clock lane, all driven by one slot sequencer.
// The clock lane is an ordinary lane loaded with a constant pattern,
// so it is phase-aligned with the data by construction.
// Assumes bit_clk is 7x pix_clk and phase-locked to it: pixel rise in slot 0, fall in slot 4.
module ser7_tx #(
    parameter int unsigned LANES       = 3,
    parameter int unsigned BITS        = 7,
    parameter int unsigned SAMPLE_SLOT = 2
) (
    input  logic                   bit_clk,
    input  logic                   pix_clk,
    input  logic                   shutdown_n,
    input  logic                   edge_sel,
    input  logic [LANES*BITS-1:0]  pix_data,
    output logic [LANES:0]         lane_out,
    output logic [LANES:0]         lane_en
);

    localparam int unsigned W       = LANES * BITS;
    localparam int unsigned HI_SLOTS = (BITS + 1) / 2;
    localparam logic [BITS-1:0] CLK_WORD = BITS'(ser7_pkg::lead_ones(BITS, HI_SLOTS));

    logic [W-1:0] cap_rise;
    logic [W-1:0] cap_fall;
    logic [W-1:0] word;
    logic         load;
    logic         active;

    ser7_capture #(.W(W)) u_capture (
        .pix_clk    (pix_clk),
        .shutdown_n (shutdown_n),
        .pix_data   (pix_data),
        .cap_rise   (cap_rise),
        .cap_fall   (cap_fall)
    );

    ser7_seq #(.BITS(BITS), .W(W), .SAMPLE_SLOT(SAMPLE_SLOT)) u_seq (
        .bit_clk    (bit_clk),
        .shutdown_n (shutdown_n),
        .edge_sel   (edge_sel),
        .cap_rise   (cap_rise),
        .cap_fall   (cap_fall),
        .load       (load),
        .word       (word),
        .active     (active)
    );

    // One data lane per bus group, in ascending bus-bit order.
    for (genvar g = 0; g < LANES; g++) begin : g_data
        ser7_lane #(.BITS(BITS)) u_lane (
            .bit_clk    (bit_clk),
            .shutdown_n (shutdown_n),
            .load       (load),
            .din        (word[g*BITS +: BITS]),
            .sout       (lane_out[g])
        );
    end

    // Clock lane: same shifter, constant high-first pattern.
    ser7_lane #(.BITS(BITS)) u_clk_lane (
        .bit_clk    (bit_clk),
        .shutdown_n (shutdown_n),
        .load       (load),
        .din        (CLK_WORD),
        .sout       (lane_out[LANES])
    );

    assign lane_en = {(LANES + 1){active}};

endmodule

// File: rtl/ser7_tx_chk.sv
// Module: ser7_tx_chk
// Port-level protocol checks for ser7_tx, attached by bind.
// Assumes shutdown is released on a word boundary.
module ser7_tx_chk #(
    parameter int unsigned NL = 4
) (
    input logic          bit_clk,
    input logic          shutdown_n,
    input logic [NL-1:0] lane_out,
    input logic [NL-1:0] lane_en
);

    logic ck;
    assign ck = lane_out[NL-1];

    logic sd_q = 1'b1;

    // Remember the shutdown level of the previous edge.
    always_ff @(posedge bit_clk) begin
        sd_q <= shutdown_n;
    end

    // A shutdown edge leaves every lane bit and enable low (R6).
    always @(posedge bit_clk) begin
        if (!sd_q) begin
            assert_shutdown_quiet_R6: assert (lane_en == '0 && lane_out == '0)
                else $error("shutdown did not silence lanes");
        end
    end

    assert_clk_high_run_R5: assert property (@(posedge bit_clk) disable iff (!shutdown_n)
        (lane_en[NL-1] && $rose(ck)) |=> ck ##1 ck ##1 ck ##1 !ck);

    assert_clk_low_run_R5: assert property (@(posedge bit_clk) disable iff (!shutdown_n)
        (lane_en[NL-1] && $fell(ck)) |=> !ck ##1 !ck ##1 ck);

    assert_first_slot_zero_word_R7: assert property (@(posedge bit_clk) disable iff (!shutdown_n)
        $rose(lane_en[0]) |-> (lane_out == {1'b1, {(NL-1){1'b0}}}));

    assert_enables_uniform_R8: assert property (@(posedge bit_clk) disable iff (!shutdown_n)
        (lane_en == '0) || (lane_en == '1));

    assert_enable_holds_R8: assert property (@(posedge bit_clk) disable iff (!shutdown_n)
        lane_en[0] |=> lane_en[0]);

endmodule

bind ser7_tx ser7_tx_chk #(.NL(LANES + 1)) u_chk (
    .bit_clk    (bit_clk),
    .shutdown_n (shutdown_n),
    .lane_out   (lane_out),
    .lane_en    (lane_en)
);

// File: tb/ser7_tx_bench.sv
// Bench for ser7_tx: a behavioural per-cycle model indexed by word period and slot.
module ser7_tx_bench;

    localparam int TCLK  = 10;
    localparam int LANES = 3;
    localparam int BITS  = 7;
    localparam int W     = LANES * BITS;
    localparam int PP    = BITS * TCLK;
    localparam int OFS   = 3;
    localparam int NP    = 240;
    localparam int REL1  = 2;
    localparam int DOWN  = 100;
    localparam int REL2  = 110;

    logic           bit_clk    = 1'b0;
    logic           pix_clk    = 1'b0;
    logic           shutdown_n = 1'b0;
    logic           edge_sel   = 1'b1;
    logic [W-1:0]   pix_data   = '0;
    logic [LANES:0] lane_out;
    logic [LANES:0] lane_en;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int rel_j  = 0;
    bit done   = 1'b0;

    ser7_tx #(.LANES(LANES), .BITS(BITS), .SAMPLE_SLOT(2)) u_ser7_tx (
        .bit_clk    (bit_clk),
        .pix_clk    (pix_clk),
        .shutdown_n (shutdown_n),
        .edge_sel   (edge_sel),
        .pix_data   (pix_data),
        .lane_out   (lane_out),
        .lane_en    (lane_en)
    );

    always #(TCLK / 2) bit_clk = ~bit_clk;

    // Pixel clock: rises OFS after the bit edge opening slot 0, high for four slots.
    initial begin
        #(TCLK / 2 + OFS);
        forever begin
            pix_clk = 1'b1;
            #(4 * TCLK);
            pix_clk = 1'b0;
            #(3 * TCLK);
        end
    end

    function automatic logic [W-1:0] a_word(input int k);
        if (k == 5) return '1;
        if (k == 6) return '0;
        if (k == 7) return 21'h0AAAAA;
        if (k == 8) return 21'h000041;
        return W'((k * 32'h9E3779B1) >> 5);
    endfunction

    function automatic logic [W-1:0] b_word(input int k);
        return ~a_word(k);
    endfunction

    function automatic logic sel_of(input int k);
        if (k < 40) return 1'b1;
        if (k < 80) return 1'b0;
        return ((k / 3) % 2) == 0;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
        end
    endtask

    // Record which cycle opens with shutdown still low (the model's release marker).
    always @(posedge bit_clk) begin
        if (!shutdown_n) rel_j = cyc;
        cyc = cyc + 1;
    end

    // Reference model compared every cycle, away from the active edge.
    always @(negedge bit_clk) begin
        if (cyc > 0 && !done) begin
            int j;
            int s;
            int p;
            bit dis;
            logic [W-1:0] wd;
            logic [LANES-1:0] de;
            j   = cyc - 1;
            s   = j % BITS;
            p   = j / BITS;
            dis = (j < rel_j + BITS);
            if (dis) begin
                // R6 R7: quiet and disabled while shut down and during the first period.
                chk("R6 R7 enables", int'(lane_en), 0);
                chk("R6 R7 lanes", int'(lane_out), 0);
            end else begin
                if (p == rel_j / BITS + 1) wd = '0;
                else wd = sel_of(p - 1) ? b_word(p - 2) : a_word(p - 2);
                for (int l = 0; l < LANES; l++) de[l] = wd[l * BITS + BITS - 1 - s];
                chk("R8 enables", int'(lane_en), (1 << (LANES + 1)) - 1);
                // R1 R2 R3 R4 (R7 for the zero word): data lane bit per slot.
                chk("R1 R2 R3 R4 R7 data", int'(lane_out[LANES-1:0]), int'(de));
                chk("R5 clock lane", int'(lane_out[LANES]), (s < 4) ? 1 : 0);
            end
        end
    end

    // Stimulus: two words per period so that the two capture edges see different data.
    initial begin
        for (int k = 0; k < NP; k++) begin
            #1;
            edge_sel = sel_of(k);
            #9;
            if (k == REL1 || k == REL2) shutdown_n = 1'b1;
            #18;
            pix_data = a_word(k);
            #12;
            if (k == DOWN) shutdown_n = 1'b0;
            #18;
            pix_data = b_word(k);
            #12;
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PP * (NP + 50));
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule